// File: doc/BRIEF.md
# Card host status and interrupt unit

This block collects the status of an SD/MMC card host and turns it into one interrupt request line. The command engine, the data engine and the card socket are outside the block; they appear here as inputs. The engines send single-cycle event pulses, for example a finished command, a response or data CRC result, a timeout, the end of a data phase, or a FIFO running empty or full. The block latches each pulse into a sticky status bit. Card presence and the write-protect switch arrive as raw levels. Each passes through a two-flop synchronizer and is reported live. A change of the synchronized card-presence level, in either direction, latches a further sticky event.

Software reaches the block through a small word register port. It can read the status word and read or write an interrupt enable mask. It can also write a clear register in which every one bit drops the matching sticky bit. The interrupt output is a registered OR of all enabled sticky bits. It therefore stays high until software has cleared every enabled cause or has masked it off.

Top module: `cardhost_irq_unit`

## Requirements
- R1: A one on event input bit k (k = 0..9) in a cycle sets status bit k after that clock edge. The bit then stays at one until it is cleared. Positions: 0 response CRC fail, 1 data CRC fail, 2 response timeout, 3 data timeout, 4 response CRC ok, 5 data CRC ok, 6 command sent, 7 data end, 8 FIFO underrun, 9 FIFO overrun.
- R2: A write to the clear register (byte offset 44) clears each sticky status bit 0..10 whose data bit is one. Bits written as zero leave their status bit unchanged.
- R3: If an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R4: Status bit 11 shows the card-absent input (1 = no card) and bit 12 shows the write-protect input, each two clock edges after the input changes. A clear write does not change either bit.
- R5: Status bit 10 (card change) is set one edge after the synchronized card-absent level changes, on a rising or a falling change.
- R6: The mask register (byte offset 48) is readable and writable in bits 0..10, with the same bit positions as the status word. Its bits 11..31 read as zero.
- R7: The interrupt output is high one edge after any status bit 0..10 and its mask bit are both one. With the mask at zero it stays low whatever the status.
- R8: The interrupt output stays high while at least one enabled sticky bit remains set. Clearing an unrelated bit does not drop it.
- R9: The status word is read at byte offset 40 and reads zero in bits 13..31. The clear register and any other offset read as zero.
- R10: After reset all sticky bits, the mask and the interrupt output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 10 | Single-cycle event pulses from the engines, one bit for each status position 0..9 |
| card_absent_i | input | 1 | Raw card-presence level, 1 when no card is in the socket |
| wr_lock_i | input | 1 | Raw write-protect level |
| addr_i | input | 7 | Byte offset into the register port |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational from the register state |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The sticky path is driven with single and combined pulses, then with clear words of all zeros, of single bits, and aimed at a bit that is being set in the same cycle. This separates plain storage from clearing and from the rule that a set wins. The interrupt path is tried with a zero mask, with a mask that covers only a bit that is not pending, and with a mask that covers the pending bit. These cases show whether the output really gates status by mask and whether it arrives one edge late. The raw levels are toggled in both directions and sampled edge by edge. This shows the two-flop latency, the card-change event on both edges, and that the live bits cannot be cleared.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;

    // status word layout (positions shared by status, clear and mask)
    localparam int unsigned N_EVT    = 10;
    localparam int unsigned BIT_CHG  = 10;
    localparam int unsigned N_STICKY = 11;
    localparam int unsigned BIT_CD   = 11;
    localparam int unsigned BIT_WP   = 12;
    localparam int unsigned N_LIVE   = 2;

    // byte offsets of the register port
    localparam int unsigned OFS_STAT = 40;
    localparam int unsigned OFS_CLR  = 44;
    localparam int unsigned OFS_MASK = 48;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wr_lock;
        logic card_absent;
    } live_lvl_t;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_STAT: s = SEL_STAT;
            OFS_CLR:  s = SEL_CLR;
            OFS_MASK: s = SEL_MASK;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/chs_sync.sv
module chs_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] pipe_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe_q[s] <= '0;
                else     pipe_q[s] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe_q[s] <= '0;
                else     pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/chs_sticky.sv
module chs_sticky #(
    parameter int unsigned N = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);
    logic [N-1:0] st_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                st_q[i] <= 1'b0;
            else if (set_i[i])
                st_q[i] <= 1'b1;
            else if (clr_i[i])
                st_q[i] <= 1'b0;
        end
    end

    assign stat_o = st_q;

    // R1: a set bit only falls when a clear hit it
    p_sticky_hold_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(st_q) & ~$past(clr_i) & ~st_q) == '0));

    // R3: a pulse always leaves its bit set, even under a clear
    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_i) & ~st_q) == '0));
endmodule

// File: rtl/chs_irq.sv
module chs_irq #(
    parameter int unsigned N = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] stat_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(stat_i & mask_i);
    end

    assign irq_o = irq_q;

    // R7: a zero mask keeps the line low
    p_mask_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (mask_i == '0) |=> !irq_q);

    // R8: the line holds while an enabled cause persists
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_q && ((stat_i & mask_i) != '0)) |=> irq_q);
endmodule

// File: rtl/cardhost_irq_unit.sv
module cardhost_irq_unit
    import card_stat_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              card_absent_i,
    input  logic              wr_lock_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    localparam int unsigned PAD_W = DATA_W - N_STICKY - N_LIVE;

    reg_sel_e            sel;
    live_lvl_t           lvl_raw, lvl_sync;
    logic                cd_prev_q;
    logic                card_chg;
    logic [N_STICKY-1:0] set_vec, clr_vec, stat, mask_q;

    assign sel = decode_ofs(32'(addr_i));

    assign lvl_raw.card_absent = card_absent_i;
    assign lvl_raw.wr_lock     = wr_lock_i;

    chs_sync #(.W(N_LIVE), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (lvl_raw),
        .sync_o (lvl_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) cd_prev_q <= 1'b0;
        else     cd_prev_q <= lvl_sync.card_absent;
    end

    assign card_chg = lvl_sync.card_absent ^ cd_prev_q;
    assign set_vec  = {card_chg, evt_i};
    assign clr_vec  = (wr_en_i && sel == SEL_CLR) ? wr_data_i[N_STICKY-1:0] : '0;

    chs_sticky #(.N(N_STICKY)) u_sticky (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .stat_o (stat)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr_en_i && sel == SEL_MASK)
            mask_q <= wr_data_i[N_STICKY-1:0];
    end

    chs_irq #(.N(N_STICKY)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .stat_i (stat),
        .mask_i (mask_q),
        .irq_o  (irq_o)
    );

    always_comb begin
        case (sel)
            SEL_STAT: rd_data_o = {{PAD_W{1'b0}}, lvl_sync.wr_lock,
                                   lvl_sync.card_absent, stat};
            SEL_MASK: rd_data_o = {{(DATA_W-N_STICKY){1'b0}}, mask_q};
            default:  rd_data_o = '0;
        endcase
    end

    // R5: a change of the synchronized presence level latches bit 10
    p_card_chg_r5: assert property (@(posedge clk) disable iff (rst)
        (lvl_sync.card_absent != cd_prev_q) |=> stat[BIT_CHG]);

    // R9: undefined status bits read zero
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[DATA_W-1:BIT_WP+1] == '0);
endmodule

// File: tb/sim_cardhost_irq_unit.sv
module sim_cardhost_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] A_STAT = 7'd40;
    localparam logic [6:0] A_CLR  = 7'd44;
    localparam logic [6:0] A_MASK = 7'd48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  evt = '0;
    logic        cd_raw = 1'b0;
    logic        wp_raw = 1'b0;
    logic [6:0]  addr = A_STAT;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cardhost_irq_unit u0 (
        .clk(clk), .rst(rst), .evt_i(evt), .card_absent_i(cd_raw),
        .wr_lock_i(wp_raw), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    // drive at a falling edge, let one rising edge pass, return at next fall
    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = A_STAT;
    endtask

    task automatic pulse(input logic [9:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_STAT, v); check("R10 status", v, 32'h0);
        rd(A_MASK, v); check("R10 mask", v, 32'h0);
        check("R10 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_sticky;
        logic [31:0] v;
        pulse(10'h048);
        rd(A_STAT, v); check("R1 set bits 3,6", v, 32'h48);
        repeat (3) @(negedge clk);
        rd(A_STAT, v); check("R1 held", v, 32'h48);
        pulse(10'h200);
        rd(A_STAT, v); check("R1 overrun added", v, 32'h248);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(A_CLR, 32'h0);
        rd(A_STAT, v); check("R2 zero clear no effect", v, 32'h248);
        wr(A_CLR, 32'h8);
        rd(A_STAT, v); check("R2 clear bit 3", v, 32'h240);
        wr(A_CLR, 32'h240);
        rd(A_STAT, v); check("R2 clear rest", v, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        pulse(10'h020);
        addr = A_CLR; wdata = 32'h20; wr_en = 1'b1; evt = 10'h020;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        rd(A_STAT, v); check("R3 set beats clear", v, 32'h20);
        wr(A_CLR, 32'h20);
        rd(A_STAT, v); check("R3 cleared after", v, 32'h0);
    endtask

    task automatic t_mask_irq;
        logic [31:0] v;
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, v); check("R6 mask width", v, 32'h7FF);
        wr(A_MASK, 32'h0);
        rd(A_MASK, v); check("R6 mask zero", v, 32'h0);
        pulse(10'h080);
        @(negedge clk);
        check("R7 masked off", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h1);
        @(negedge clk);
        check("R7 other bit enabled", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h80);
        check("R7 not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R7 raised", {31'b0, irq}, 32'h1);
        pulse(10'h001);
        wr(A_CLR, 32'h1);
        @(negedge clk);
        check("R8 unrelated clear", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'h80);
        check("R8 one edge late", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R8 dropped", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h200);
        pulse(10'h200);
        check("R7 timing before", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R7 timing after", {31'b0, irq}, 32'h1);
        wr(A_MASK, 32'h0);
        wr(A_CLR, 32'h7FF);
    endtask

    task automatic t_levels;
        logic [31:0] v;
        wp_raw = 1'b1;
        @(negedge clk);
        rd(A_STAT, v); check("R4 wp after one edge", v, 32'h0);
        @(negedge clk);
        rd(A_STAT, v); check("R4 wp after two edges", v, 32'h1000);
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_STAT, v); check("R4 wp not clearable", v, 32'h1000);
        wp_raw = 1'b0; cd_raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(A_STAT, v); check("R4 cd live", v, 32'h800);
        @(negedge clk);
        rd(A_STAT, v); check("R5 rising change", v, 32'hC00);
        wr(A_CLR, 32'h1C00);
        rd(A_STAT, v); check("R4 cd not clearable", v, 32'h800);
        cd_raw = 1'b0;
        repeat (3) @(negedge clk);
        rd(A_STAT, v); check("R5 falling change", v, 32'h400);
        wr(A_CLR, 32'h400);
    endtask

    task automatic t_reads;
        logic [31:0] v;
        pulse(10'h3FF);
        rd(A_STAT, v); check("R9 status upper zero", v, 32'h3FF);
        rd(A_CLR, v);  check("R9 clear reads zero", v, 32'h0);
        rd(7'd0, v);   check("R9 other offset zero", v, 32'h0);
        wr(A_CLR, 32'h3FF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_clear();
        t_set_wins();
        t_mask_irq();
        t_levels();
        t_reads();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule